// File: doc/BRIEF.md
# Maskable Burst Address Counter

This block generates the address for one port of a synchronous memory. A value taken from the external address bus seeds a counter. The counter then advances by one on every clock, so a burst reaches successive words without a new address for each word.

A mask register sets how many low-order bits take part in counting, and so where the burst wraps. Bits above the mask keep the value they were loaded with. A counter-reset input returns only the counting bits to zero.

The current count or the mask can be placed on a readback output. An active-low flag reports that the counting field has reached its last value before wrapping.

The mask must be a contiguous run of ones that starts at bit 0. It is written from the address bus with a dedicated load strobe. The synchronous reset gives a full-width mask, a zero count and a released flag.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `addr_o` is 0, the mask is all ones and `wrap_n` is 1.
- R2: With `cntrst_n`=1, `ads_n`=0 and `cnten_n`=0 at a rising edge, `addr_o` equals `addr_i` after that edge.
- R3: With `cntrst_n`=1, `ads_n`=1 and `cnten_n`=0, the masked low field of width k advances by one modulo 2^k at each edge. Bits above the mask are unchanged.
- R4: With `cntrst_n`=1 and `cnten_n`=1, the counter and `wrap_n` keep their values, whatever `ads_n` is.
- R5: With an all-ones mask, repeated increments cover the whole address space, and the value after 2^AW-1 is 0.
- R6: `cntrst_n`=0 clears only the masked bits of the counter and keeps the bits above them. It takes priority over load and increment, and it releases `wrap_n` to 1.
- R7: `mask_ld`=1 writes `addr_i` into the mask at the edge. A counter operation in that same cycle still uses the mask held before the edge.
- R8: `rdback_o` shows the counter when `rb_sel`=0 and the mask when `rb_sel`=1.
- R9: `wrap_n` goes to 0 after an increment edge that leaves every masked bit at 1. It stays at 0 through later increments and holds, and returns to 1 after the next load or counter reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| cnten_n | input | 1 | Counter enable, active low |
| cntrst_n | input | 1 | Counter reset of the masked bits, active low |
| mask_ld | input | 1 | Writes the mask from `addr_i`, active high |
| rb_sel | input | 1 | Readback select: 0 counter, 1 mask |
| addr_i | input | AW | External address bus |
| addr_o | output | AW | Current counter address |
| rdback_o | output | AW | Counter or mask, as chosen by `rb_sel` |
| wrap_n | output | 1 | Wrap flag, active low |

## Verification
The mask write and a counter operation can happen at the same edge. The bench raises `mask_ld` together with an increment, a load or a counter reset. It then checks that this edge's result follows the old mask and that the next increment follows the new one.

Counter reset and load can also be requested together. The bench drives `cntrst_n`, `ads_n` and `cnten_n` all low at once and expects the masked bits to clear rather than the bus value to load.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_INC  = 2'd1,
        CTR_LOAD = 2'd2,
        CTR_CLR  = 2'd3
    } ctr_op_e;

    // Priority: counter reset, load, increment, hold.
    function automatic ctr_op_e decode_op(input logic cntrst_n,
                                          input logic ads_n,
                                          input logic cnten_n);
        if (!cntrst_n)
            return CTR_CLR;
        else if (!cnten_n && !ads_n)
            return CTR_LOAD;
        else if (!cnten_n)
            return CTR_INC;
        else
            return CTR_HOLD;
    endfunction

endpackage

// File: rtl/burst_mask_reg.sv
module burst_mask_reg #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] mask_o
);

    logic [AW-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (ld)
            mask_q <= d;
    end

    assign mask_o = mask_q;

    // R1
    mask_rst_chk: assert property (@(posedge clk) rst |=> (mask_q == '1));

    // R7
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(mask_q));

endmodule

// File: rtl/burst_ctr_core.sv
module burst_ctr_core
    import burst_ctr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctr_op_e       op,
    input  logic [AW-1:0] load_val,
    input  logic [AW-1:0] mask_i,
    output logic [AW-1:0] cnt_o,
    output logic          wrap_o
);

    logic [AW-1:0] cnt_q, cnt_nxt;
    logic          wrap_q, wrap_nxt;
    logic [AW-1:0] keep_bits, bumped;

    assign keep_bits = cnt_q & ~mask_i;
    assign bumped    = cnt_q + {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        cnt_nxt  = cnt_q;
        wrap_nxt = wrap_q;
        unique case (op)
            CTR_CLR: begin
                cnt_nxt  = keep_bits;
                wrap_nxt = 1'b0;
            end
            CTR_LOAD: begin
                cnt_nxt  = load_val;
                wrap_nxt = 1'b0;
            end
            CTR_INC: begin
                cnt_nxt  = keep_bits | (bumped & mask_i);
                wrap_nxt = wrap_q | ((cnt_nxt & mask_i) == mask_i);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            wrap_q <= wrap_nxt;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;

    // R1
    cnt_rst_chk: assert property (@(posedge clk) rst |=> (cnt_q == '0 && !wrap_q));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_HOLD) |=> ($stable(cnt_q) && $stable(wrap_q)));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_INC) |=> ((cnt_q & ~$past(mask_i)) == ($past(cnt_q) & ~$past(mask_i))));

    // R6
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_CLR) |=> ((cnt_q & $past(mask_i)) == '0 &&
                             (cnt_q & ~$past(mask_i)) == ($past(cnt_q) & ~$past(mask_i))));

    // R9
    wrap_release_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_CLR || op == CTR_LOAD) |=> !wrap_q);

    // R9
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && op == CTR_INC) |=> wrap_q);

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_ctr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ads_n,
    input  logic          cnten_n,
    input  logic          cntrst_n,
    input  logic          mask_ld,
    input  logic          rb_sel,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] rdback_o,
    output logic          wrap_n
);

    ctr_op_e       op;
    logic [AW-1:0] mask;
    logic [AW-1:0] cnt;
    logic          wrap;

    always_comb op = decode_op(cntrst_n, ads_n, cnten_n);

    burst_mask_reg #(.AW(AW)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .ld     (mask_ld),
        .d      (addr_i),
        .mask_o (mask)
    );

    burst_ctr_core #(.AW(AW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (addr_i),
        .mask_i   (mask),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    assign addr_o   = cnt;
    assign rdback_o = rb_sel ? mask : cnt;
    assign wrap_n   = ~wrap;

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (cntrst_n && !ads_n && !cnten_n) |=> (addr_o == $past(addr_i)));

    // R6
    clr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (!cntrst_n && !ads_n && !cnten_n) |=> ((addr_o & $past(mask)) == '0));

endmodule

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ads_n = 1'b1, cnten_n = 1'b1, cntrst_n = 1'b1;
    logic          mask_ld = 1'b0, rb_sel = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o, rdback_o;
    logic          wrap_n;

    int n_run = 0, n_fail = 0;
    int exp_cnt = 0, exp_mask = (1 << AW) - 1;
    bit exp_wrap = 0;

    always #5 clk = ~clk;

    burst_addr_ctr #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .ads_n(ads_n), .cnten_n(cnten_n),
        .cntrst_n(cntrst_n), .mask_ld(mask_ld), .rb_sel(rb_sel),
        .addr_i(addr_i), .addr_o(addr_o), .rdback_o(rdback_o), .wrap_n(wrap_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the arithmetic model, check outputs.
    task automatic cyc(input string tag, input bit a_n, input bit e_n,
                       input bit r_n, input bit mld, input int a, input bit sel);
        int k, span, low;
        ads_n = a_n; cnten_n = e_n; cntrst_n = r_n; mask_ld = mld;
        addr_i = a[AW-1:0]; rb_sel = sel;
        @(posedge clk);
        #2;
        k = $countones(exp_mask[AW-1:0]);
        span = 1 << k;
        if (!r_n) begin
            exp_cnt = exp_cnt - (exp_cnt % span);
            exp_wrap = 0;
        end else if (!a_n && !e_n) begin
            exp_cnt = a % (1 << AW);
            exp_wrap = 0;
        end else if (!e_n) begin
            low = ((exp_cnt % span) + 1) % span;
            exp_cnt = exp_cnt - (exp_cnt % span) + low;
            if (low == span - 1) exp_wrap = 1;
        end
        if (mld) exp_mask = a % (1 << AW);
        chk({tag, " addr"}, int'(addr_o), exp_cnt);
        chk("R9 wrap", int'(wrap_n), exp_wrap ? 0 : 1);
        chk("R8 readback", int'(rdback_o), sel ? exp_mask : exp_cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        // R1 reset state
        rb_sel = 1'b1;
        #1;
        chk("R1 mask", int'(rdback_o), (1 << AW) - 1);
        chk("R1 addr", int'(addr_o), 0);
        chk("R1 wrap", int'(wrap_n), 1);
        rst = 1'b0;
        cyc("R1", 1, 1, 1, 0, 0, 0);

        // R5 full-mask wrap through the whole space
        cyc("R2", 0, 0, 1, 0, 60, 0);
        for (int i = 0; i < 70; i++) cyc("R5", 1, 0, 1, 0, 0, i % 2);

        // R4 stall with strobe toggling
        for (int i = 0; i < 6; i++) cyc("R4", i % 2, 1, 1, 0, 33, 0);

        // R3 / R9 sweep over every mask width and several seeds
        for (int k = 1; k <= AW; k++) begin
            cyc("R7", 1, 1, 1, 1, (1 << k) - 1, 1);
            for (int s = 0; s < 4; s++) begin
                cyc("R2", 0, 0, 1, 0, s * 21, 0);
                for (int i = 0; i < (1 << k) + 2; i++)
                    cyc("R3", 1, 0, 1, 0, 0, i % 3 == 0);
            end
        end

        // R6 counter reset keeps upper bits, beats a load
        cyc("R7", 1, 1, 1, 1, 7, 0);
        cyc("R2", 0, 0, 1, 0, 45, 0);
        cyc("R3", 1, 0, 1, 0, 0, 0);
        cyc("R3", 1, 0, 1, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 18, 0);
        cyc("R3", 1, 0, 1, 0, 0, 0);
        cyc("R6", 1, 0, 0, 0, 0, 0);

        // R7 mask write coinciding with increment, load and reset
        cyc("R7", 1, 1, 1, 1, (1 << AW) - 1, 1);
        cyc("R2", 0, 0, 1, 0, 5, 0);
        cyc("R7", 1, 0, 1, 1, 3, 1);
        cyc("R7", 1, 0, 1, 0, 0, 0);
        cyc("R7", 1, 0, 1, 0, 0, 0);
        cyc("R7", 0, 0, 1, 1, 15, 1);
        cyc("R7", 1, 0, 1, 0, 0, 0);
        cyc("R7", 1, 1, 0, 1, 1, 1);
        cyc("R7", 1, 0, 1, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule